// File: doc/BRIEF.md
# Linkable Four-Channel Interval Timer

This block provides four programmable down-counting timers for a system that runs from one fast clock. Each channel reloads from an 8-bit divisor and emits an underflow event once per period. A channel is clocked either by the fast clock or by a shared slow base tick. The slow tick comes from a prescaler that divides the fast clock by 28 or by 114. Two neighbouring channels can be joined into one 16-bit counter. A single strobe restarts every counter at once, so software can place the first underflow on a known cycle.

Three of the four channels (channels 1, 2 and 4) can raise interrupts. Software enables them through one register and clears them through the same register. It reads their pending state back, active low. The `irq_n` output goes low while any interrupt is pending. All configuration goes through a plain write bus with a 3-bit address. Reads are combinational on `rdata` and decode the same address.

Top module: `quad_interval_timer`

Register map (3-bit address):

| Address | Write | Read |
|---|---|---|
| 0 to 3 | divisor of channels 1 to 4 | zero |
| 4 | control register | zero |
| 5 | start strobe (data ignored) | zero |
| 6 | interrupt enable | status |
| 7 | prescaler halt (bit 0) | zero |

Control register bits (address 4):

| Bit | Function when set |
|---|---|
| 6 | channel 1 runs from the fast clock |
| 5 | channel 3 runs from the fast clock |
| 4 | channels 1 and 2 are linked into one 16-bit counter |
| 3 | channels 3 and 4 are linked into one 16-bit counter |
| 0 | slow base is fast clock / 114; when clear it is fast clock / 28 |

## Requirements
- R1: After synchronous reset, a read of address 6 returns 8'hFF and `irq_n` is high.
- R2: An unlinked channel on the fast clock (channel 1 with control bit 6, channel 3 with control bit 5) underflows every divisor+4 fast cycles.
- R3: With control bit 4 (pair 1+2) or bit 3 (pair 3+4) set, the pair counts as one 16-bit value. The lower channel's divisor is the low byte and the upper channel's divisor is the high byte. On the fast clock the pair underflows every value+7 cycles. The underflow is reported on the upper channel (2 or 4), and the lower channel raises no interrupt.
- R4: Slow-clocked counting uses the base tick: fast/114 when control bit 0 is 1, fast/28 when it is 0. An unlinked channel on the base tick underflows every (divisor+1) ticks, and a linked pair every (value+1) ticks. Channels 2 and 4 always use the base tick unless they are linked.
- R5: Any write to address 5 reloads every counter at once. The first underflow then comes exactly one period after the strobe's clock edge.
- R6: Write data bits 0, 1 and 2 of address 6 enable the interrupts of channels 1, 2 and 4. A pending bit sets on an underflow only while its enable bit is 1. Channel 3 never raises an interrupt.
- R7: Writing address 6 with an enable bit 0 clears that channel's pending interrupt on the same edge.
- R8: A read of address 6 returns the pending bits of channels 1, 2 and 4 inverted in bits 0, 1 and 2, and ones in bits 7 to 3.
- R9: `irq_n` is low exactly while at least one interrupt is pending.
- R10: Writing 1 to bit 0 of address 7 halts the prescaler, and no slow-clocked channel underflows while halted. Writing 0 lets it run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst | input | 1 | synchronous reset, active high |
| wr_en | input | 1 | register write strobe |
| addr | input | 3 | register address for writes and reads |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, status at address 6, else zero |
| irq_n | output | 1 | interrupt request, active low |

## Verification
The bench builds the block with its default values: 8-bit divisors, base divisors of 28 and 114, and fire latencies of 4 and 7. With these values every period the bench checks fits inside a few thousand cycles, including 16-bit values up to 0x1234. The bench sweeps the 8-bit divisor from 0 to 255 and a spread of 16-bit values on both pairs. It counts both the cycles from the strobe to the first underflow and the cycles between underflows. Slow-base cases are checked only on the second interval, because the strobe does not realign the prescaler phase.

// File: rtl/qit_pkg.sv
package qit_pkg;
   // register addresses
   localparam int unsigned AW       = 3;
   localparam int unsigned A_DIV0   = 0;
   localparam int unsigned A_CTRL   = 4;
   localparam int unsigned A_STRB   = 5;
   localparam int unsigned A_IRQ    = 6;
   localparam int unsigned A_HALT   = 7;
   // control bit positions
   localparam int unsigned CB_FAST1  = 6;
   localparam int unsigned CB_FAST3  = 5;
   localparam int unsigned CB_LINK12 = 4;
   localparam int unsigned CB_LINK34 = 3;
   localparam int unsigned CB_BASE   = 0;
   // channels and interrupt sources
   localparam int unsigned NCH  = 4;
   localparam int unsigned NIRQ = 3;
endpackage

// File: rtl/qit_prescaler.sv
module qit_prescaler #(
   parameter int unsigned DIV_A = 28,
   parameter int unsigned DIV_B = 114
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       halt,
   output logic [1:0] tick
);
   if (DIV_A < 2 || DIV_B < 2) begin : g_bad_div
      $error("qit_prescaler: base divisors must be at least 2");
   end

   for (genvar g = 0; g < 2; g++) begin : g_base
      localparam int unsigned N = (g == 0) ? DIV_A : DIV_B;
      localparam int unsigned W = $clog2(N);
      logic [W-1:0] cnt;

      assign tick[g] = !halt && (cnt == W'(N - 1));

      always_ff @(posedge clk) begin
         if (rst || halt) cnt <= '0;
         else if (tick[g]) cnt <= '0;
         else cnt <= cnt + 1'b1;
      end

      assert_base_gap_R4 : assert property (@(posedge clk) disable iff (rst)
         tick[g] |=> !tick[g]);
      assert_halt_silent_R10 : assert property (@(posedge clk) disable iff (rst)
         halt |=> !tick[g]);
   end
endmodule

// File: rtl/qit_pair.sv
module qit_pair #(
   parameter int unsigned DW    = 8,
   parameter int unsigned LAT8  = 4,
   parameter int unsigned LAT16 = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          slow_tick,
   input  logic          fast_sel,
   input  logic          link,
   input  logic          load,
   input  logic [DW-1:0] div_lo,
   input  logic [DW-1:0] div_hi,
   output logic          fire_lo,
   output logic          fire_hi
);
   localparam int unsigned SW = DW + 1;
   localparam int unsigned LW = 2 * DW + 1;

   logic [SW-1:0] cnt_lo, cnt_hi, rel_lo, rel_hi;
   logic [LW-1:0] cnt_w, rel_w;
   logic          tick_lo, z_lo, z_hi, z_w;

   assign tick_lo = fast_sel | slow_tick;
   assign rel_lo  = fast_sel ? SW'(div_lo) + SW'(LAT8 - 1) : SW'(div_lo);
   assign rel_hi  = SW'(div_hi);
   assign rel_w   = fast_sel ? LW'({div_hi, div_lo}) + LW'(LAT16 - 1)
                             : LW'({div_hi, div_lo});
   assign z_lo = (cnt_lo == '0);
   assign z_hi = (cnt_hi == '0);
   assign z_w  = (cnt_w == '0);

   assign fire_lo = !link && tick_lo && z_lo;
   assign fire_hi = link ? (tick_lo && z_w) : (slow_tick && z_hi);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
         cnt_w  <= '0;
      end else if (load) begin
         cnt_lo <= rel_lo;
         cnt_hi <= rel_hi;
         cnt_w  <= rel_w;
      end else begin
         if (tick_lo) begin
            cnt_lo <= z_lo ? rel_lo : cnt_lo - 1'b1;
            cnt_w  <= z_w ? rel_w : cnt_w - 1'b1;
         end
         if (slow_tick) cnt_hi <= z_hi ? rel_hi : cnt_hi - 1'b1;
      end
   end
endmodule

// File: rtl/qit_irq.sv
module qit_irq #(
   parameter int unsigned NIRQ = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [NIRQ-1:0] wval,
   input  logic [NIRQ-1:0] src,
   output logic [NIRQ-1:0] pend
);
   logic [NIRQ-1:0] en_q, en_nxt;

   assign en_nxt = we ? wval : en_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= '0;
         pend <= '0;
      end else begin
         en_q <= en_nxt;
         pend <= en_nxt & (pend | src);
      end
   end

   for (genvar g = 0; g < NIRQ; g++) begin : g_chk
      assert_set_needs_fire_R6 : assert property (@(posedge clk) disable iff (rst)
         $rose(pend[g]) |-> $past(src[g]));
      assert_write_clears_R7 : assert property (@(posedge clk) disable iff (rst)
         (we && !wval[g]) |=> !pend[g]);
   end
endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
   import qit_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned DIV_A  = 28,
   parameter int unsigned DIV_B  = 114,
   parameter int unsigned LAT8   = 4,
   parameter int unsigned LAT16  = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          irq_n
);
   if (DW < 8) begin : g_bad_dw
      $error("quad_interval_timer: DW must be at least 8");
   end
   if (LAT8 < 1 || LAT16 < 1 || LAT8 > (1 << DW) || LAT16 > (1 << DW)) begin : g_bad_lat
      $error("quad_interval_timer: latencies out of range");
   end

   logic [DW-1:0]   div_q [NCH];
   logic            fast1_q, fast3_q, link12_q, link34_q, base_q, halt_q;
   logic [1:0]      base_tick;
   logic            slow_tick, strobe;
   logic [NCH-1:0]  fire;
   logic [NIRQ-1:0] pend;

   assign strobe = wr_en && (addr == AW'(A_STRB));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NCH; i++) div_q[i] <= '0;
         fast1_q  <= 1'b0;
         fast3_q  <= 1'b0;
         link12_q <= 1'b0;
         link34_q <= 1'b0;
         base_q   <= 1'b0;
         halt_q   <= 1'b0;
      end else if (wr_en) begin
         if (addr[AW-1] == 1'b0) div_q[addr[1:0]] <= wdata;
         if (addr == AW'(A_CTRL)) begin
            fast1_q  <= wdata[CB_FAST1];
            fast3_q  <= wdata[CB_FAST3];
            link12_q <= wdata[CB_LINK12];
            link34_q <= wdata[CB_LINK34];
            base_q   <= wdata[CB_BASE];
         end
         if (addr == AW'(A_HALT)) halt_q <= wdata[0];
      end
   end

   qit_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .halt (halt_q),
      .tick (base_tick)
   );

   assign slow_tick = base_q ? base_tick[1] : base_tick[0];

   for (genvar p = 0; p < NCH / 2; p++) begin : g_pair
      qit_pair #(.DW(DW), .LAT8(LAT8), .LAT16(LAT16)) u_pair (
         .clk       (clk),
         .rst       (rst),
         .slow_tick (slow_tick),
         .fast_sel  ((p == 0) ? fast1_q : fast3_q),
         .link      ((p == 0) ? link12_q : link34_q),
         .load      (strobe),
         .div_lo    (div_q[2*p]),
         .div_hi    (div_q[2*p+1]),
         .fire_lo   (fire[2*p]),
         .fire_hi   (fire[2*p+1])
      );
   end

   qit_irq #(.NIRQ(NIRQ)) u_irq (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && (addr == AW'(A_IRQ))),
      .wval (wdata[NIRQ-1:0]),
      .src  ({fire[3], fire[1], fire[0]}),
      .pend (pend)
   );

   assign rdata = (addr == AW'(A_IRQ)) ? {{(DW-NIRQ){1'b1}}, ~pend} : '0;
   assign irq_n = ~|pend;

   assert_linked_lo_quiet_R3 : assert property (@(posedge clk) disable iff (rst)
      link12_q |-> !fire[0]);
   assert_linked_lo3_quiet_R3 : assert property (@(posedge clk) disable iff (rst)
      link34_q |-> !fire[2]);
endmodule

// File: tb/quad_interval_timer_tb.sv
module quad_interval_timer_tb;
   import qit_pkg::*;

   localparam int LIM = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'(A_IRQ);
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;
   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   quad_interval_timer u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input int a, input int d);
      wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0; addr = 3'(A_IRQ); wdata = '0;
   endtask

   // first: cycles from strobe edge to first underflow; second: next interval
   task automatic measure(input int en, input int b, output int first, output int second);
      int k;
      wr(A_IRQ, 0);
      wr(A_STRB, 0);
      wr(A_IRQ, en);
      k = 1;
      while (rdata[b] && k < LIM) begin @(negedge clk); k++; end
      first = k;
      chk(irq_n == 1'b0, "R9 irq_n low while pending", int'(irq_n), 0);
      chk(rdata == 8'(~(8'd1 << b)), "R8 status image", int'(rdata), int'(8'(~(8'd1 << b))));
      wr(A_IRQ, 0);
      chk(rdata == 8'hFF && irq_n, "R7 clear by enable write", int'(rdata), 255);
      wr(A_IRQ, en);
      k = 2;
      while (rdata[b] && k < LIM) begin @(negedge clk); k++; end
      second = k;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int f, s;
      int d8 [8] = '{0, 1, 2, 3, 7, 100, 200, 255};
      int d16 [5] = '{0, 1, 255, 256, 4660};
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rdata == 8'hFF, "R1 status after reset", int'(rdata), 255);
      chk(irq_n == 1'b1, "R1 irq_n after reset", int'(irq_n), 1);

      // R6: underflows without enable leave nothing pending
      wr(A_DIV0, 0);
      wr(A_CTRL, 1 << CB_FAST1);
      repeat (20) @(negedge clk);
      chk(rdata == 8'hFF && irq_n, "R6 disabled underflow ignored", int'(rdata), 255);

      // R2/R5: 8-bit fast sweep on channel 1
      foreach (d8[i]) begin
         wr(A_DIV0, d8[i]);
         measure(1, 0, f, s);
         chk(f == d8[i] + 4, "R5 first period 8-bit", f, d8[i] + 4);
         chk(s == d8[i] + 4, "R2 period 8-bit fast", s, d8[i] + 4);
      end

      // R3: linked pair 1+2, irq on channel 2 (status bit 1)
      wr(A_CTRL, (1 << CB_FAST1) | (1 << CB_LINK12));
      foreach (d16[i]) begin
         wr(A_DIV0, d16[i] & 255);
         wr(A_DIV0 + 1, d16[i] >> 8);
         measure(2, 1, f, s);
         chk(f == d16[i] + 7, "R5 first period 16-bit", f, d16[i] + 7);
         chk(s == d16[i] + 7, "R3 period pair 1+2", s, d16[i] + 7);
      end

      // R3: lower channel silent while linked
      wr(A_DIV0, 0); wr(A_DIV0 + 1, 0);
      wr(A_IRQ, 0); wr(A_STRB, 0); wr(A_IRQ, 1);
      repeat (50) @(negedge clk);
      chk(rdata == 8'hFF && irq_n, "R3 channel 1 quiet when linked", int'(rdata), 255);

      // R3: linked pair 3+4 on fast clock, irq on channel 4 (status bit 2)
      wr(A_CTRL, (1 << CB_FAST3) | (1 << CB_LINK34));
      wr(A_DIV0 + 2, 3); wr(A_DIV0 + 3, 0);
      measure(4, 2, f, s);
      chk(s == 3 + 7, "R3 period pair 3+4 small", s, 10);
      wr(A_DIV0 + 2, 1); wr(A_DIV0 + 3, 2);
      measure(4, 2, f, s);
      chk(f == 513 + 7, "R5 first period pair 3+4", f, 520);
      chk(s == 513 + 7, "R3 period pair 3+4 byte order", s, 520);

      // R6: channel 3 has no interrupt
      wr(A_DIV0, 255); wr(A_DIV0 + 1, 255); wr(A_DIV0 + 2, 0); wr(A_DIV0 + 3, 255);
      wr(A_CTRL, (1 << CB_FAST3) | (1 << CB_BASE));
      wr(A_IRQ, 0); wr(A_STRB, 0); wr(A_IRQ, 7);
      repeat (60) @(negedge clk);
      chk(rdata == 8'hFF && irq_n, "R6 channel 3 raises nothing", int'(rdata), 255);

      // R4: slow base clocks
      wr(A_CTRL, 0);
      wr(A_DIV0 + 1, 2);
      measure(2, 1, f, s);
      chk(s == 3 * 28, "R4 channel 2 on /28", s, 84);
      wr(A_CTRL, 1 << CB_BASE);
      wr(A_DIV0 + 1, 1);
      measure(2, 1, f, s);
      chk(s == 2 * 114, "R4 channel 2 on /114", s, 228);
      wr(A_DIV0, 0);
      measure(1, 0, f, s);
      chk(s == 114, "R4 channel 1 slow on /114", s, 114);
      wr(A_CTRL, 0);
      wr(A_DIV0 + 3, 3);
      measure(4, 2, f, s);
      chk(s == 4 * 28, "R4 channel 4 on /28", s, 112);
      wr(A_CTRL, 1 << CB_LINK12);
      wr(A_DIV0, 1); wr(A_DIV0 + 1, 0);
      measure(2, 1, f, s);
      chk(s == 2 * 28, "R4 linked pair on /28", s, 56);

      // R10: halt stops slow channels
      wr(A_CTRL, 0);
      wr(A_DIV0 + 1, 0);
      wr(A_HALT, 1);
      wr(A_IRQ, 0); wr(A_STRB, 0); wr(A_IRQ, 2);
      repeat (300) @(negedge clk);
      chk(rdata == 8'hFF && irq_n, "R10 no underflow while halted", int'(rdata), 255);
      wr(A_HALT, 0);
      repeat (60) @(negedge clk);
      chk(rdata[1] == 1'b0, "R10 resumes after halt release", int'(rdata[1]), 0);
      chk(irq_n == 1'b0, "R9 irq_n after resume", int'(irq_n), 0);

      summary();
      $finish;
   end
endmodule